// File: doc/BRIEF.md
# Program Counter Branch Unit

This block computes the next fetch address for a core whose program counter is a 21-bit byte address and whose instructions are 16-bit words. Each cycle it takes the current address and a decoded instruction class. Depending on the class it also uses a signed word offset, a 20-bit absolute word target, the four status flags, or the operands of a skip test. From these it produces the next program counter.

Relative transfers land at the current address plus 2 plus twice the sign-extended offset. Conditional branches use an 8-bit offset and test one of four flags for set or clear. Unconditional relative branches and relative calls use an 11-bit offset. Absolute jumps and calls place their operand in address bits 20..1.

Every taken transfer raises a redirect for one cycle. The following cycle is marked as a bubble, and the unit ignores its input during that cycle. A skip test that succeeds raises a skip request. The next valid instruction is then squashed into a no-op: the address advances past that instruction (by 4 if it is a two-word instruction) and it has no effect.

Top module: `pc_branch_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, redirect_o, skip_o, squash_o and bubble_o are 0; no skip is pending after reset.
- R2: A valid, non-squashed instruction of the sequential class (cls_i=0) gives next_pc_o = pc_i+2, or pc_i+4 when two_word_i is 1, with redirect_o=0.
- R3: A conditional branch (cls_i=1) is taken when flags_i[cond_i[2:1]] XOR cond_i[0] is 1, where flags_i bit 0 is carry, bit 1 is zero, bit 2 is overflow and bit 3 is negative. When taken, next_pc_o = pc_i+2+2*sext(off_i[7:0]) and redirect_o=1; off_i[10:8] is ignored.
- R4: An untaken conditional branch gives next_pc_o = pc_i+2 with redirect_o=0 and no bubble in the next cycle.
- R5: An unconditional relative branch (cls_i=2) or relative call (cls_i=3) is always taken, with next_pc_o = pc_i+2+2*sext(off_i[10:0]) modulo 2^21 and redirect_o=1.
- R6: An absolute jump (cls_i=4) or absolute call (cls_i=5) gives next_pc_o = {abs_i, 1'b0} and redirect_o=1.
- R7: In the cycle after redirect_o=1, bubble_o=1. In that cycle the input instruction has no effect: next_pc_o = pc_i, and redirect_o, skip_o and squash_o are 0.
- R8: A skip test (cls_i=6) with skip_kind_i 0, 1 or 2 raises skip_o when file_i equals, is greater than, or is less than wreg_i respectively, comparing both as unsigned bytes. Its next_pc_o is pc_i+2.
- R9: skip_kind_i 3 skips when file_i is zero; kind 4 skips when file_i[bit_sel_i] is 0; kind 5 skips when it is 1; kinds 10..15 never skip.
- R10: skip_kind_i 6/7 skip when file_i+1 (8-bit) is zero/non-zero; kinds 8/9 skip when file_i-1 is zero/non-zero.
- R11: The next valid non-bubble instruction after skip_o=1 is squashed: squash_o=1, redirect_o=0, skip_o=0, next_pc_o = pc_i+2, or pc_i+4 when two_word_i is 1. The instruction after it is not squashed.
- R12: In a cycle with valid_i=0, next_pc_o = pc_i and redirect_o, skip_o and squash_o are 0. A pending skip is kept across such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| pc_i | input | 21 | Byte address of the current instruction |
| cls_i | input | 4 | Instruction class: 0 seq, 1 cond branch, 2 rel branch, 3 rel call, 4 abs jump, 5 abs call, 6 skip test |
| two_word_i | input | 1 | Current instruction occupies two words |
| cond_i | input | 3 | Conditional branch flavour: [2:1] flag select, [0] branch on clear |
| off_i | input | 11 | Signed word offset (low 8 bits for conditional branches) |
| abs_i | input | 20 | Absolute word target |
| flags_i | input | 4 | {negative, overflow, zero, carry} |
| skip_kind_i | input | 4 | Skip test selector |
| file_i | input | 8 | File operand for skip tests |
| wreg_i | input | 8 | Working register for compare skips |
| bit_sel_i | input | 3 | Bit index for bit skips |
| next_pc_o | output | 21 | Next program counter |
| redirect_o | output | 1 | Taken transfer, flush the fetched word |
| skip_o | output | 1 | Skip request for the following instruction |
| squash_o | output | 1 | Current instruction is nullified |
| bubble_o | output | 1 | Second cycle of a two-cycle transfer |

## Verification
Conditional branches are driven with every flag flavour, both taken and untaken. Their offsets are chosen to be positive, negative and at the most negative value, with high offset bits set so that a decoder using the wrong width gives a different target. The long relative forms are tried at both ends of their offset range and across the address wrap. Absolute targets use an all-ones operand, which tells a shifted load apart from an unshifted one. Compare skips use 0x80 against 0x7F in both orders, which separates unsigned from signed compares. The squash path is tried with a plain instruction, a two-word instruction, a taken branch, another skip and an idle cycle in between.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
  typedef enum logic [3:0] {
    CLS_SEQ   = 4'd0,
    CLS_BCOND = 4'd1,
    CLS_BRA   = 4'd2,
    CLS_RCALL = 4'd3,
    CLS_GOTO  = 4'd4,
    CLS_CALL  = 4'd5,
    CLS_SKIP  = 4'd6
  } pbu_cls_e;

  typedef enum logic [3:0] {
    SK_EQ    = 4'd0,
    SK_GT    = 4'd1,
    SK_LT    = 4'd2,
    SK_ZERO  = 4'd3,
    SK_BCLR  = 4'd4,
    SK_BSET  = 4'd5,
    SK_INCZ  = 4'd6,
    SK_INCNZ = 4'd7,
    SK_DECZ  = 4'd8,
    SK_DECNZ = 4'd9
  } pbu_skip_e;
endpackage

// File: rtl/pbu_rel_target.sv
module pbu_rel_target #(
  parameter int PC_W  = 21,
  parameter int OFS_W = 11
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] off_i,
  output logic [PC_W-1:0]  tgt_o
);
  localparam int EXT_W = PC_W - OFS_W - 1;

  logic [PC_W-1:0] byte_ofs;

  // word offset -> byte offset, sign extended to PC width
  assign byte_ofs = {{EXT_W{off_i[OFS_W-1]}}, off_i, 1'b0};
  assign tgt_o    = pc_i + PC_W'(2) + byte_ofs;
endmodule

// File: rtl/pbu_flag_cond.sv
module pbu_flag_cond (
  input  logic [3:0] flags_i,
  input  logic [2:0] cond_i,
  output logic       taken_o
);
  // cond_i[2:1] picks the flag, cond_i[0] inverts the sense
  assign taken_o = flags_i[cond_i[2:1]] ^ cond_i[0];
endmodule

// File: rtl/pbu_skip_test.sv
module pbu_skip_test import pbu_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic [3:0]                kind_i,
  input  logic [DATA_W-1:0]         file_i,
  input  logic [DATA_W-1:0]         wreg_i,
  input  logic [$clog2(DATA_W)-1:0] bit_sel_i,
  output logic                      skip_o
);
  logic [DATA_W-1:0] inc_v, dec_v;
  logic              sel_bit;

  assign inc_v   = file_i + DATA_W'(1);
  assign dec_v   = file_i - DATA_W'(1);
  assign sel_bit = file_i[bit_sel_i];

  always_comb begin
    unique case (pbu_skip_e'(kind_i))
      SK_EQ:    skip_o = (file_i == wreg_i);
      SK_GT:    skip_o = (file_i > wreg_i);
      SK_LT:    skip_o = (file_i < wreg_i);
      SK_ZERO:  skip_o = (file_i == '0);
      SK_BCLR:  skip_o = !sel_bit;
      SK_BSET:  skip_o = sel_bit;
      SK_INCZ:  skip_o = (inc_v == '0);
      SK_INCNZ: skip_o = (inc_v != '0);
      SK_DECZ:  skip_o = (dec_v == '0);
      SK_DECNZ: skip_o = (dec_v != '0);
      default:  skip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit import pbu_pkg::*; #(
  parameter int PC_W        = 21,
  parameter int ABS_W       = 20,
  parameter int LOFS_W      = 11,
  parameter int SOFS_W      = 8,
  parameter int DATA_W      = 8,
  parameter bit SHARE_ADDER = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [PC_W-1:0]           pc_i,
  input  logic [3:0]                cls_i,
  input  logic                      two_word_i,
  input  logic [2:0]                cond_i,
  input  logic [LOFS_W-1:0]         off_i,
  input  logic [ABS_W-1:0]          abs_i,
  input  logic [3:0]                flags_i,
  input  logic [3:0]                skip_kind_i,
  input  logic [DATA_W-1:0]         file_i,
  input  logic [DATA_W-1:0]         wreg_i,
  input  logic [$clog2(DATA_W)-1:0] bit_sel_i,
  output logic [PC_W-1:0]           next_pc_o,
  output logic                      redirect_o,
  output logic                      skip_o,
  output logic                      squash_o,
  output logic                      bubble_o
);
  localparam int SEXT_W = LOFS_W - SOFS_W;

  pbu_cls_e        cls;
  logic            skip_pend_q, bubble_q;
  logic            active, live;
  logic            cond_taken, skip_hit;
  logic [PC_W-1:0] rel_tgt, abs_tgt, seq_pc;

  assign cls     = pbu_cls_e'(cls_i);
  assign active  = valid_i && !bubble_q;
  assign live    = active && !skip_pend_q;
  assign abs_tgt = {abs_i, 1'b0};
  assign seq_pc  = pc_i + (two_word_i ? PC_W'(4) : PC_W'(2));

  pbu_flag_cond u_cond (
    .flags_i (flags_i),
    .cond_i  (cond_i),
    .taken_o (cond_taken)
  );

  pbu_skip_test #(.DATA_W(DATA_W)) u_skip (
    .kind_i    (skip_kind_i),
    .file_i    (file_i),
    .wreg_i    (wreg_i),
    .bit_sel_i (bit_sel_i),
    .skip_o    (skip_hit)
  );

  generate
    if (SHARE_ADDER) begin : g_shared
      logic [LOFS_W-1:0] off_sel;
      assign off_sel = (cls == CLS_BCOND)
                     ? {{SEXT_W{off_i[SOFS_W-1]}}, off_i[SOFS_W-1:0]}
                     : off_i;
      pbu_rel_target #(.PC_W(PC_W), .OFS_W(LOFS_W)) u_tgt (
        .pc_i  (pc_i),
        .off_i (off_sel),
        .tgt_o (rel_tgt)
      );
    end else begin : g_split
      logic [PC_W-1:0] tgt_s, tgt_l;
      pbu_rel_target #(.PC_W(PC_W), .OFS_W(SOFS_W)) u_tgt_s (
        .pc_i  (pc_i),
        .off_i (off_i[SOFS_W-1:0]),
        .tgt_o (tgt_s)
      );
      pbu_rel_target #(.PC_W(PC_W), .OFS_W(LOFS_W)) u_tgt_l (
        .pc_i  (pc_i),
        .off_i (off_i),
        .tgt_o (tgt_l)
      );
      assign rel_tgt = (cls == CLS_BCOND) ? tgt_s : tgt_l;
    end
  endgenerate

  always_comb begin
    redirect_o = 1'b0;
    skip_o     = 1'b0;
    next_pc_o  = pc_i;
    if (active) begin
      next_pc_o = seq_pc;
      if (live) begin
        case (cls)
          CLS_BCOND: if (cond_taken) begin
            redirect_o = 1'b1;
            next_pc_o  = rel_tgt;
          end
          CLS_BRA, CLS_RCALL: begin
            redirect_o = 1'b1;
            next_pc_o  = rel_tgt;
          end
          CLS_GOTO, CLS_CALL: begin
            redirect_o = 1'b1;
            next_pc_o  = abs_tgt;
          end
          CLS_SKIP: skip_o = skip_hit;
          default: ;
        endcase
      end
    end
  end

  assign squash_o = active && skip_pend_q;
  assign bubble_o = bubble_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      skip_pend_q <= 1'b0;
      bubble_q    <= 1'b0;
    end else begin
      bubble_q <= redirect_o;
      if (active) skip_pend_q <= skip_o;
    end
  end
endmodule

// File: rtl/pbu_checker.sv
module pbu_checker #(
  parameter int PC_W = 21
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [PC_W-1:0] pc_i,
  input logic            two_word_i,
  input logic [PC_W-1:0] next_pc_o,
  input logic            redirect_o,
  input logic            skip_o,
  input logic            squash_o,
  input logic            bubble_o,
  input logic            skip_pend_q
);
  always @(negedge clk_i)
    if (!rst_ni)
      a_r1_quiet_in_reset: assert (!bubble_o && !squash_o && !skip_pend_q);

  a_r7_bubble_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> bubble_o);

  a_r7_bubble_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o |-> (!redirect_o && !skip_o && !squash_o && next_pc_o == pc_i));

  a_r11_squash_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> (!redirect_o && !skip_o));

  a_r11_skip_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> skip_pend_q);

  a_r11_squash_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |=> !skip_pend_q);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!redirect_o && !skip_o && !squash_o && next_pc_o == pc_i));

  a_r12_idle_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(skip_pend_q));

  a_r6_even_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !pc_i[0]) |-> !next_pc_o[0]);

  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bubble_o && !redirect_o && !two_word_i) |-> next_pc_o == pc_i + PC_W'(2));
endmodule

bind pc_branch_unit pbu_checker #(.PC_W(PC_W)) u_pbu_checker (.*);

// File: tb/tb_pc_branch_unit.sv
`timescale 1ns/1ps
module tb_pc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, two_word_i = 1'b0;
  logic [20:0] pc_i = '0;
  logic [3:0]  cls_i = '0, flags_i = '0, skip_kind_i = 4'hF;
  logic [2:0]  cond_i = '0, bit_sel_i = '0;
  logic [10:0] off_i = '0;
  logic [19:0] abs_i = '0;
  logic [7:0]  file_i = '0, wreg_i = '0;
  logic [20:0] next_pc_o;
  logic        redirect_o, skip_o, squash_o, bubble_o;

  always #5 clk = ~clk;

  pc_branch_unit dut (.*, .clk_i(clk));

  typedef struct {
    logic [20:0] pc;
    bit rd, sk, sq, bb;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  bit done = 0;

  // staging values, copied to the DUT by step()
  logic        s_valid, s_tw;
  logic [20:0] s_pc;
  logic [3:0]  s_cls, s_flags, s_kind;
  logic [2:0]  s_cond, s_bsel;
  logic [10:0] s_off;
  logic [19:0] s_abs;
  logic [7:0]  s_file, s_w;

  task automatic prep(input logic [3:0] c, input logic [20:0] p);
    s_valid = 1'b1; s_tw = 1'b0; s_pc = p; s_cls = c; s_flags = '0;
    s_kind = 4'hF; s_cond = '0; s_bsel = '0; s_off = '0; s_abs = '0;
    s_file = '0; s_w = '0;
  endtask

  task automatic step(input logic [20:0] e_pc, input bit rd, sk, sq, bb,
                      input string tag);
    exp_t e;
    @(posedge clk); #1;
    valid_i = s_valid; two_word_i = s_tw; pc_i = s_pc; cls_i = s_cls;
    flags_i = s_flags; skip_kind_i = s_kind; cond_i = s_cond;
    bit_sel_i = s_bsel; off_i = s_off; abs_i = s_abs; file_i = s_file;
    wreg_i = s_w;
    e.pc = e_pc; e.rd = rd; e.sk = sk; e.sq = sq; e.bb = bb; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic skipt(input logic [3:0] k, input logic [7:0] f, w,
                       input logic [2:0] b, input logic [20:0] p);
    prep(4'd6, p); s_kind = k; s_file = f; s_w = w; s_bsel = b;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (next_pc_o !== e.pc || redirect_o !== e.rd || skip_o !== e.sk ||
          squash_o !== e.sq || bubble_o !== e.bb) begin
        failures++;
        $display("FAIL %s: actual pc=%h rd=%b sk=%b sq=%b bb=%b expected pc=%h rd=%b sk=%b sq=%b bb=%b",
                 e.tag, next_pc_o, redirect_o, skip_o, squash_o, bubble_o,
                 e.pc, e.rd, e.sk, e.sq, e.bb);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    pc_i = 21'h000123;
    repeat (3) @(negedge clk);
    checks++;
    if (redirect_o !== 0 || skip_o !== 0 || squash_o !== 0 || bubble_o !== 0 ||
        next_pc_o !== 21'h000123) begin
      failures++;
      $display("FAIL R1 reset: actual rd=%b sk=%b sq=%b bb=%b pc=%h expected 0 0 0 0 000123",
               redirect_o, skip_o, squash_o, bubble_o, next_pc_o);
    end
    rst_ni = 1'b1;

    // R1 / R2
    prep(4'd0, 21'h100);             step(21'h102, 0,0,0,0, "R1 first cycle after reset");
    prep(4'd0, 21'h100); s_tw = 1;   step(21'h104, 0,0,0,0, "R2 two-word seq");
    prep(4'd0, 21'h1FFFFE);          step(21'h000000, 0,0,0,0, "R2 seq wrap");

    // R3 taken, then R7 bubble ignores a matching skip
    prep(4'd1, 21'h010); s_cond = 3'd0; s_flags = 4'b0001; s_off = 11'h005;
    step(21'h01C, 1,0,0,0, "R3 carry set taken");
    skipt(4'd0, 8'h55, 8'h55, 3'd0, 21'h01C);
    step(21'h01C, 0,0,0,1, "R7 bubble ignores skip");
    prep(4'd0, 21'h01C);             step(21'h01E, 0,0,0,0, "R7 no squash after bubble");

    prep(4'd1, 21'h200); s_cond = 3'd3; s_off = 11'h0FE;
    step(21'h1FE, 1,0,0,0, "R3 zero clear taken negative offset");
    prep(4'd0, 21'h1FE); s_valid = 0; step(21'h1FE, 0,0,0,1, "R7 bubble idle");

    prep(4'd1, 21'h010); s_cond = 3'd2; s_flags = 4'b0010; s_off = 11'h001;
    step(21'h014, 1,0,0,0, "R3 zero set taken");
    prep(4'd0, 21'h014); s_valid = 0; step(21'h014, 0,0,0,1, "R7 bubble");
    prep(4'd1, 21'h020); s_cond = 3'd5; s_flags = 4'b1011; s_off = 11'h002;
    step(21'h026, 1,0,0,0, "R3 overflow clear taken");
    prep(4'd0, 21'h026); s_valid = 0; step(21'h026, 0,0,0,1, "R7 bubble");
    prep(4'd1, 21'h020); s_cond = 3'd1; s_flags = 4'b0000; s_off = 11'h002;
    step(21'h026, 1,0,0,0, "R3 carry clear taken");
    prep(4'd0, 21'h026); s_valid = 0; step(21'h026, 0,0,0,1, "R7 bubble");

    // R4 untaken
    prep(4'd1, 21'h300); s_cond = 3'd4; s_flags = 4'b1011; s_off = 11'h010;
    step(21'h302, 0,0,0,0, "R4 overflow set untaken");
    prep(4'd1, 21'h300); s_cond = 3'd7; s_flags = 4'b1000; s_off = 11'h010;
    step(21'h302, 0,0,0,0, "R4 negative clear untaken");
    prep(4'd0, 21'h302);             step(21'h304, 0,0,0,0, "R4 no bubble after untaken");

    // R3 upper offset bits ignored, most negative short offset
    prep(4'd1, 21'h1000); s_cond = 3'd6; s_flags = 4'b1000; s_off = 11'h480;
    step(21'h0F02, 1,0,0,0, "R3 offset -128 high bits ignored");
    prep(4'd0, 21'h0F02); s_valid = 0; step(21'h0F02, 0,0,0,1, "R7 bubble");

    // R5
    prep(4'd2, 21'h1000); s_off = 11'h400;
    step(21'h0802, 1,0,0,0, "R5 branch offset -1024");
    prep(4'd0, 21'h0802); s_valid = 0; step(21'h0802, 0,0,0,1, "R7 bubble");
    prep(4'd3, 21'h0000); s_off = 11'h3FF;
    step(21'h0800, 1,0,0,0, "R5 rel call offset +1023");
    prep(4'd0, 21'h0800); s_valid = 0; step(21'h0800, 0,0,0,1, "R7 bubble");
    prep(4'd2, 21'h0000); s_off = 11'h7FE;
    step(21'h1FFFFE, 1,0,0,0, "R5 wrap below zero");
    prep(4'd0, 21'h0); s_valid = 0; step(21'h0, 0,0,0,1, "R7 bubble");

    // R6
    prep(4'd4, 21'h040); s_abs = 20'hFFFFF; s_tw = 1;
    step(21'h1FFFFE, 1,0,0,0, "R6 abs jump all ones");
    prep(4'd0, 21'h0); s_valid = 0; step(21'h0, 0,0,0,1, "R7 bubble");
    prep(4'd5, 21'h040); s_abs = 20'h12345; s_tw = 1;
    step(21'h2468A, 1,0,0,0, "R6 abs call");
    prep(4'd0, 21'h0); s_valid = 0; step(21'h0, 0,0,0,1, "R7 bubble");

    // R8 / R11
    skipt(4'd0, 8'h80, 8'h80, 3'd0, 21'h400); step(21'h402, 0,1,0,0, "R8 equal skips");
    prep(4'd0, 21'h402);                      step(21'h404, 0,0,1,0, "R11 squash seq");
    prep(4'd0, 21'h404);                      step(21'h406, 0,0,0,0, "R11 one instruction only");
    skipt(4'd1, 8'h80, 8'h7F, 3'd0, 21'h500); step(21'h502, 0,1,0,0, "R8 greater unsigned");
    prep(4'd0, 21'h502); s_tw = 1;            step(21'h506, 0,0,1,0, "R11 squash two-word");
    skipt(4'd2, 8'h7F, 8'h80, 3'd0, 21'h600); step(21'h602, 0,1,0,0, "R8 less unsigned");
    prep(4'd4, 21'h602); s_tw = 1; s_abs = 20'h00001;
    step(21'h606, 0,0,1,0, "R11 squashed jump no redirect");
    prep(4'd0, 21'h606);                      step(21'h608, 0,0,0,0, "R11 no bubble after squashed jump");
    skipt(4'd2, 8'h80, 8'h7F, 3'd0, 21'h700); step(21'h702, 0,0,0,0, "R8 not less unsigned");
    skipt(4'd1, 8'h7F, 8'h80, 3'd0, 21'h700); step(21'h702, 0,0,0,0, "R8 not greater unsigned");
    skipt(4'd0, 8'h01, 8'h02, 3'd0, 21'h700); step(21'h702, 0,0,0,0, "R8 not equal");

    // R9 / R12
    skipt(4'd3, 8'h00, 8'h00, 3'd0, 21'h800); step(21'h802, 0,1,0,0, "R9 zero skips");
    prep(4'd0, 21'h802); s_valid = 0;         step(21'h802, 0,0,0,0, "R12 idle no squash");
    prep(4'd0, 21'h802);                      step(21'h804, 0,0,1,0, "R12 pending kept over idle");
    skipt(4'd3, 8'h01, 8'h00, 3'd0, 21'h804); step(21'h806, 0,0,0,0, "R9 nonzero no skip");
    skipt(4'd4, 8'hFB, 8'h00, 3'd2, 21'h900); step(21'h902, 0,1,0,0, "R9 bit clear skips");
    skipt(4'd5, 8'hFB, 8'h00, 3'd3, 21'h902); step(21'h904, 0,0,1,0, "R11 squashed skip raises none");
    prep(4'd0, 21'h904);                      step(21'h906, 0,0,0,0, "R11 squashed skip leaves none pending");
    skipt(4'd5, 8'hFB, 8'h00, 3'd2, 21'h906); step(21'h908, 0,0,0,0, "R9 bit set false");
    skipt(4'd5, 8'hFB, 8'h00, 3'd3, 21'h908); step(21'h90A, 0,1,0,0, "R9 bit set true");
    prep(4'd1, 21'h90A); s_cond = 3'd0; s_flags = 4'b0001; s_off = 11'h010;
    step(21'h90C, 0,0,1,0, "R11 squashed branch no redirect");
    prep(4'd0, 21'h90C);                      step(21'h90E, 0,0,0,0, "R11 no bubble after squashed branch");
    skipt(4'd12, 8'h00, 8'h00, 3'd0, 21'h90E); step(21'h910, 0,0,0,0, "R9 unused kind never skips");

    // R10
    skipt(4'd6, 8'hFF, 8'h00, 3'd0, 21'hA00); step(21'hA02, 0,1,0,0, "R10 inc zero skips");
    prep(4'd0, 21'hA02);                      step(21'hA04, 0,0,1,0, "R10 squash after inc zero");
    skipt(4'd7, 8'hFF, 8'h00, 3'd0, 21'hA04); step(21'hA06, 0,0,0,0, "R10 inc nonzero false");
    skipt(4'd8, 8'h01, 8'h00, 3'd0, 21'hA06); step(21'hA08, 0,1,0,0, "R10 dec zero skips");
    prep(4'd0, 21'hA08);                      step(21'hA0A, 0,0,1,0, "R10 squash after dec zero");
    skipt(4'd9, 8'h00, 8'h00, 3'd0, 21'hA0A); step(21'hA0C, 0,1,0,0, "R10 dec nonzero wraps");
    prep(4'd0, 21'hA0C);                      step(21'hA0E, 0,0,1,0, "R10 squash after dec nonzero");
    skipt(4'd9, 8'h01, 8'h00, 3'd0, 21'hA0E); step(21'hA10, 0,0,0,0, "R10 dec nonzero false");
    skipt(4'd8, 8'h00, 8'h00, 3'd0, 21'hA10); step(21'hA12, 0,0,0,0, "R10 dec zero false");
    skipt(4'd7, 8'h00, 8'h00, 3'd0, 21'hA12); step(21'hA14, 0,1,0,0, "R10 inc nonzero skips");
    prep(4'd0, 21'hA14);                      step(21'hA16, 0,0,1,0, "R10 squash after inc nonzero");

    prep(4'd0, 21'h0); s_valid = 0; step(21'h0, 0,0,0,0, "R12 final idle");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule